// File: doc/BRIEF.md
# Multilevel Priority Interrupt Controller

This block collects interrupt requests from a bank of external request lines and from software, and decides which one the processor should take next. Each level carries two independent gates. The arm gate decides whether a new request is accepted at all; a request arriving on a disarmed level is discarded. The enable gate decides whether a recorded request may be offered to the processor; a disabled level keeps its request recorded but is held back until it is enabled again.

Levels are ranked by index, with level 0 the most urgent. The controller offers the most urgent enabled waiting level, but only while no level of equal or higher rank is already in service. When the processor acknowledges the offer, that level moves from waiting to active. A clear-active strobe ends service of the most urgent active level. A routine can trigger a less urgent level to leave remaining work for later. That level is taken only after every more urgent waiting level has been handled.

Four whole-vector registers (arm, enable, waiting, active) can be read and overwritten through a small register port. Software can therefore save the complete controller state, reassign priorities on the fly, and restore the state exactly.

Top module: `prio_intc`

## Requirements
- R1: After reset every level is disarmed, disabled, not waiting and not active, and `irq_req` is low.
- R2: Register port addresses are 0 = arm, 1 = enable, 2 = waiting, 3 = active, with bit i belonging to level i. `reg_rdata` shows the addressed register combinationally. A write replaces the whole register at the next clock edge and takes precedence over any event that would change that register in the same cycle.
- R3: A rising edge on `irq_lines[i]` of an armed level sets waiting bit i. The edge passes through a two-flop synchronizer, so the bit is set on the third rising clock edge after the line rises. A line held high produces one request only.
- R4: While a level is disarmed, edges on its line are discarded and are not recovered when the level is re-armed.
- R5: A disabled level still records a request as waiting but is never offered. It is offered once it is enabled, provided R7 allows it.
- R6: A pulse on `trig_stb` sets waiting bit `trig_lvl` at the next clock edge, under the same arm rule as an external request.
- R7: `irq_req` is high exactly when some level p is both waiting and enabled and no level with index at most p is active. `irq_lvl` is then the lowest such p, and it is 0 when `irq_req` is low.
- R8: `ack` while `irq_req` is high clears the waiting bit and sets the active bit of the offered level at the next clock edge. A new request on the same level in that cycle leaves the level waiting.
- R9: `clr_act` clears only the lowest-index active bit at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_lines | input | NLVL | External request lines, one per level |
| trig_stb | input | 1 | Software trigger strobe |
| trig_lvl | input | LW | Level to trigger |
| ack | input | 1 | Processor accepts the offered level |
| clr_act | input | 1 | End service of the most urgent active level |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | NLVL | Register write data |
| reg_rdata | output | NLVL | Selected register contents |
| irq_req | output | 1 | An interrupt is offered |
| irq_lvl | output | LW | Offered level number |

## Verification
The offer outputs depend only on state registers. Trigger, acknowledge, clear-active and register writes therefore show on `irq_req`/`irq_lvl` one clock edge after they are driven, and a rising external line shows three edges after it rises. The bench drives inputs on the falling edge and advances a behavioural model on the rising edge with the same delays. It compares the offer outputs against the model at every falling edge. `reg_rdata` is combinational on `reg_addr`, so register reads are sampled a short delay after the address is set in the low clock phase and compared with literal expected vectors.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [1:0] {
    SEL_ARM  = 2'd0,
    SEL_EN   = 2'd1,
    SEL_WAIT = 2'd2,
    SEL_ACT  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] rise_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q, s3_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
        s3_q <= 1'b0;
      end else begin
        s1_q <= raw_i[g];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign rise_o[g] = s2_q & ~s3_q;
  end
endmodule

// File: rtl/intc_pick.sv
module intc_pick #(
  parameter int W  = 16,
  parameter int LW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic          any_o,
  output logic [LW-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        any_o = 1'b1;
        idx_o = LW'(i);
      end
    end
  end
endmodule

// File: rtl/intc_state.sv
module intc_state
  import intc_pkg::*;
#(
  parameter int NLVL = 16,
  parameter int LW   = $clog2(NLVL)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NLVL-1:0] rise_i,
  input  logic            trig_stb_i,
  input  logic [LW-1:0]   trig_lvl_i,
  input  logic            grant_i,
  input  logic [LW-1:0]   grant_lvl_i,
  input  logic            clr_i,
  input  logic            act_any_i,
  input  logic [LW-1:0]   act_lvl_i,
  input  logic            we_i,
  input  reg_sel_e        sel_i,
  input  logic [NLVL-1:0] wdata_i,
  output logic [NLVL-1:0] arm_o,
  output logic [NLVL-1:0] en_o,
  output logic [NLVL-1:0] wt_o,
  output logic [NLVL-1:0] ac_o
);
  logic [NLVL-1:0] arm_q, en_q, wt_q, ac_q;
  logic [NLVL-1:0] arm_d, en_d, wt_d, ac_d;
  logic [NLVL-1:0] trig_vec, new_req, grant_vec, clr_vec;

  always_comb begin
    trig_vec  = trig_stb_i ? (NLVL'(1) << trig_lvl_i) : '0;
    new_req   = (rise_i | trig_vec) & arm_q;
    grant_vec = grant_i ? (NLVL'(1) << grant_lvl_i) : '0;
    clr_vec   = (clr_i && act_any_i) ? (NLVL'(1) << act_lvl_i) : '0;

    arm_d = arm_q;
    en_d  = en_q;
    wt_d  = (wt_q & ~grant_vec) | new_req;
    ac_d  = (ac_q & ~clr_vec) | grant_vec;

    if (we_i) begin
      unique case (sel_i)
        SEL_ARM:  arm_d = wdata_i;
        SEL_EN:   en_d  = wdata_i;
        SEL_WAIT: wt_d  = wdata_i;
        SEL_ACT:  ac_d  = wdata_i;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= '0;
      en_q  <= '0;
      wt_q  <= '0;
      ac_q  <= '0;
    end else begin
      arm_q <= arm_d;
      en_q  <= en_d;
      wt_q  <= wt_d;
      ac_q  <= ac_d;
    end
  end

  assign arm_o = arm_q;
  assign en_o  = en_q;
  assign wt_o  = wt_q;
  assign ac_o  = ac_q;
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter int NLVL = 16,
  parameter int LW   = $clog2(NLVL)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NLVL-1:0] irq_lines,
  input  logic            trig_stb,
  input  logic [LW-1:0]   trig_lvl,
  input  logic            ack,
  input  logic            clr_act,
  input  logic            reg_we,
  input  logic [1:0]      reg_addr,
  input  logic [NLVL-1:0] reg_wdata,
  output logic [NLVL-1:0] reg_rdata,
  output logic            irq_req,
  output logic [LW-1:0]   irq_lvl
);
  logic rst_m_q, rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_n <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_n <= rst_m_q;
    end
  end

  logic [NLVL-1:0] rise_v, arm_v, en_v, wt_v, ac_v;
  logic            pend_any, act_any;
  logic [LW-1:0]   pend_lvl, act_lvl;
  reg_sel_e        sel;

  assign sel = reg_sel_e'(reg_addr);

  intc_sync #(.W(NLVL)) u_sync (
    .clk(clk), .rst_n(rst_s_n), .raw_i(irq_lines), .rise_o(rise_v)
  );

  intc_pick #(.W(NLVL), .LW(LW)) u_pick_pend (
    .vec_i(wt_v & en_v), .any_o(pend_any), .idx_o(pend_lvl)
  );

  intc_pick #(.W(NLVL), .LW(LW)) u_pick_act (
    .vec_i(ac_v), .any_o(act_any), .idx_o(act_lvl)
  );

  always_comb begin
    irq_req = pend_any && (!act_any || (act_lvl > pend_lvl));
    irq_lvl = irq_req ? pend_lvl : '0;
  end

  intc_state #(.NLVL(NLVL), .LW(LW)) u_state (
    .clk(clk), .rst_n(rst_s_n),
    .rise_i(rise_v),
    .trig_stb_i(trig_stb), .trig_lvl_i(trig_lvl),
    .grant_i(ack && irq_req), .grant_lvl_i(irq_lvl),
    .clr_i(clr_act), .act_any_i(act_any), .act_lvl_i(act_lvl),
    .we_i(reg_we), .sel_i(sel), .wdata_i(reg_wdata),
    .arm_o(arm_v), .en_o(en_v), .wt_o(wt_v), .ac_o(ac_v)
  );

  always_comb begin
    unique case (sel)
      SEL_ARM:  reg_rdata = arm_v;
      SEL_EN:   reg_rdata = en_v;
      SEL_WAIT: reg_rdata = wt_v;
      SEL_ACT:  reg_rdata = ac_v;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
  parameter int NLVL = 16,
  parameter int LW   = $clog2(NLVL)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            irq_req,
  input logic [LW-1:0]   irq_lvl,
  input logic            ack,
  input logic            clr_act,
  input logic            reg_we,
  input logic [1:0]      reg_addr,
  input logic [NLVL-1:0] arm_v,
  input logic [NLVL-1:0] en_v,
  input logic [NLVL-1:0] wt_v,
  input logic [NLVL-1:0] ac_v
);
  logic [NLVL-1:0] below_mask;
  logic [NLVL-1:0] upto_mask;
  assign below_mask = (NLVL'(1) << irq_lvl) - NLVL'(1);
  assign upto_mask  = below_mask | (NLVL'(1) << irq_lvl);

  assert_offer_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (wt_v[irq_lvl] && en_v[irq_lvl]));

  assert_offer_highest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ((wt_v & en_v & below_mask) == '0));

  assert_offer_not_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ((ac_v & upto_mask) == '0));

  assert_offer_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !en_v[irq_lvl]) |-> 1'b0);

  assert_ack_activates_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && ack && !(reg_we && reg_addr == 2'd3)) |=> ac_v[$past(irq_lvl)]);

  assert_clear_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_act && !ack && (ac_v != '0) && !(reg_we && reg_addr == 2'd3))
      |=> ($countones(ac_v) + 1 == $countones($past(ac_v))));

  assert_disarm_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_we && reg_addr == 2'd2) |-> ((wt_v & ~$past(wt_v) & ~$past(arm_v)) == '0));
endmodule

bind prio_intc intc_chk #(.NLVL(NLVL), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_s_n), .irq_req(irq_req), .irq_lvl(irq_lvl),
  .ack(ack), .clr_act(clr_act), .reg_we(reg_we), .reg_addr(reg_addr),
  .arm_v(arm_v), .en_v(en_v), .wt_v(wt_v), .ac_v(ac_v)
);

// File: tb/prio_intc_tb.sv
`timescale 1ns/1ps
module prio_intc_tb;
  localparam int N = 16;
  localparam int L = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0] irq_lines;
  logic trig_stb;
  logic [L-1:0] trig_lvl;
  logic ack, clr_act, reg_we;
  logic [1:0] reg_addr;
  logic [N-1:0] reg_wdata, reg_rdata;
  logic irq_req;
  logic [L-1:0] irq_lvl;

  always #4 clk = ~clk;

  prio_intc u_dut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .trig_stb(trig_stb),
    .trig_lvl(trig_lvl), .ack(ack), .clr_act(clr_act), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_req(irq_req), .irq_lvl(irq_lvl)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // behavioural reference model
  bit [N-1:0] m_arm, m_en, m_wt, m_ac;
  bit [N-1:0] smp0, smp1, smp2;
  bit [N-1:0] t_new, t_wt, t_ac;
  int t_p;

  function automatic int m_offer();
    for (int i = 0; i < N; i++) begin
      if (m_ac[i]) return -1;
      if (m_wt[i] && m_en[i]) return i;
    end
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_arm = '0; m_en = '0; m_wt = '0; m_ac = '0;
      smp0 = '0; smp1 = '0; smp2 = '0;
    end else begin
      t_new = smp1 & ~smp2;
      smp2 = smp1; smp1 = smp0; smp0 = irq_lines;
      if (trig_stb) t_new[trig_lvl] = 1'b1;
      t_new = t_new & m_arm;
      t_p = m_offer();
      t_wt = m_wt; t_ac = m_ac;
      if (clr_act) begin
        for (int i = 0; i < N; i++) if (m_ac[i]) begin t_ac[i] = 1'b0; break; end
      end
      if (ack && t_p >= 0) begin t_wt[t_p] = 1'b0; t_ac[t_p] = 1'b1; end
      t_wt = t_wt | t_new;
      if (reg_we) begin
        case (reg_addr)
          2'd0: m_arm = reg_wdata;
          2'd1: m_en = reg_wdata;
          2'd2: t_wt = reg_wdata;
          default: t_ac = reg_wdata;
        endcase
      end
      m_wt = t_wt; m_ac = t_ac;
    end
  end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-cycle comparison of the offer outputs
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int p;
      p = m_offer();
      check("R7 irq_req vs model", int'(irq_req), (p >= 0) ? 1 : 0);
      if (p >= 0) check("R7 irq_lvl vs model", int'(irq_lvl), p);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [N-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, logic [N-1:0] exp, string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(tag, int'(reg_rdata), int'(exp));
  endtask

  task automatic pulse(logic [N-1:0] m);
    @(negedge clk); irq_lines = irq_lines | m;
    @(negedge clk); irq_lines = irq_lines & ~m;
    tick(2);
  endtask

  task automatic trig(int l);
    @(negedge clk); trig_stb = 1'b1; trig_lvl = L'(l);
    @(negedge clk); trig_stb = 1'b0;
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic do_clr();
    @(negedge clk); clr_act = 1'b1;
    @(negedge clk); clr_act = 1'b0;
  endtask

  task automatic offer(int exp_req, int exp_lvl, string tag);
    @(negedge clk); #1;
    check(tag, int'(irq_req), exp_req);
    if (exp_req != 0) check(tag, int'(irq_lvl), exp_lvl);
  endtask

  initial begin
    logic [N-1:0] sv [4];
    rst_n = 1'b0; irq_lines = '0; trig_stb = 1'b0; trig_lvl = '0;
    ack = 1'b0; clr_act = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    tick(4);
    rst_n = 1'b1;
    tick(4);
    // R1 reset state
    rd(2'd0, 16'h0000, "R1 arm after reset");
    rd(2'd1, 16'h0000, "R1 enable after reset");
    rd(2'd2, 16'h0000, "R1 waiting after reset");
    rd(2'd3, 16'h0000, "R1 active after reset");
    offer(0, 0, "R1 no request after reset");
    // R2 register writes
    wr(2'd0, 16'hFFFF); wr(2'd1, 16'hFFFF);
    rd(2'd0, 16'hFFFF, "R2 arm readback");
    // R3 external edge
    pulse(16'h0020);
    offer(1, 5, "R3 level 5 offered after edge");
    // R7 priority among several
    pulse(16'h0208);
    offer(1, 3, "R7 most urgent of 3,5,9");
    do_ack();
    rd(2'd3, 16'h0008, "R8 level 3 active");
    rd(2'd2, 16'h0220, "R8 level 3 left waiting");
    offer(0, 0, "R7 lower levels blocked by active 3");
    do_clr();
    offer(1, 5, "R9 level 5 offered after clear");
    do_ack(); do_clr();
    offer(1, 9, "R7 level 9 next");
    do_ack();
    pulse(16'h0002);
    offer(1, 1, "R7 level 1 preempts active 9");
    do_ack();
    rd(2'd3, 16'h0202, "R8 two levels active");
    do_clr();
    rd(2'd3, 16'h0200, "R9 only most urgent active cleared");
    do_clr();
    rd(2'd3, 16'h0000, "R9 all cleared");
    // R4 disarm
    wr(2'd0, 16'hFF7F);
    pulse(16'h0080);
    rd(2'd2, 16'h0000, "R4 disarmed level ignores edge");
    wr(2'd0, 16'hFFFF);
    tick(2);
    rd(2'd2, 16'h0000, "R4 request lost after rearm");
    offer(0, 0, "R4 nothing offered");
    // R5 disable
    wr(2'd1, 16'hFFFB);
    pulse(16'h0004);
    rd(2'd2, 16'h0004, "R5 disabled level records request");
    offer(0, 0, "R5 disabled level not offered");
    wr(2'd1, 16'hFFFF);
    offer(1, 2, "R5 offered once enabled");
    do_ack(); do_clr();
    // R6 software trigger and deferral
    trig(1);
    offer(1, 1, "R6 trigger sets level 1 waiting");
    do_ack();
    trig(12); trig(4);
    rd(2'd2, 16'h1010, "R6 triggered levels waiting");
    offer(0, 0, "R6 deferred levels held while 1 active");
    do_clr();
    offer(1, 4, "R6 level 4 before deferred 12");
    do_ack(); do_clr();
    offer(1, 12, "R6 deferred level 12 served last");
    do_ack(); do_clr();
    wr(2'd0, 16'hFFFE);
    trig(0);
    rd(2'd2, 16'h0000, "R6 trigger on disarmed level dropped");
    wr(2'd0, 16'hFFFF);
    // R3 held line gives a single request
    @(negedge clk); irq_lines = 16'h0040;
    tick(4);
    offer(1, 6, "R3 held line offered");
    do_ack(); do_clr();
    tick(4);
    rd(2'd2, 16'h0000, "R3 held line does not re-request");
    @(negedge clk); irq_lines = '0;
    tick(3);
    // R2 save and restore
    wr(2'd2, 16'h0840); wr(2'd3, 16'h0001); wr(2'd1, 16'hF0F0); wr(2'd0, 16'h00FF);
    for (int a = 0; a < 4; a++) begin
      @(negedge clk); reg_addr = 2'(a); #1; sv[a] = reg_rdata;
    end
    check("R2 saved arm", int'(sv[0]), 16'h00FF);
    check("R2 saved waiting", int'(sv[2]), 16'h0840);
    for (int a = 0; a < 4; a++) wr(2'(a), 16'h0000);
    for (int a = 0; a < 4; a++) wr(2'(a), sv[a]);
    rd(2'd1, 16'hF0F0, "R2 enable restored");
    rd(2'd3, 16'h0001, "R2 active restored");
    offer(0, 0, "R7 restored active 0 blocks 6");
    do_clr();
    offer(1, 6, "R7 level 6 after restore and clear");
    // R2 write wins over same-cycle trigger
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 16'h0000;
    trig_stb = 1'b1; trig_lvl = 4'd5;
    @(negedge clk);
    reg_we = 1'b0; trig_stb = 1'b0;
    rd(2'd2, 16'h0000, "R2 write overrides trigger");
    tick(2);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule